// File: doc/BRIEF.md
# Configurable UART Frame Transceiver

This block pairs a serial transmitter with a serial receiver that share one frame format. The format comes from a small control register: a data-size bit, a parity-enable bit and a parity-sense bit. Software writes bytes through a simple register port. The transmitter turns each byte into a frame: one low start bit, the data least significant bit first, an optional parity bit, and one high stop bit. The receiver watches the serial line for a falling edge and confirms the start bit at its middle. It then samples each later bit at the middle of its 16-tick window, rebuilds the character and checks its parity.

The control register has a lock scheme. A setup bit opens a configuration window. The UART-mode bit can change only inside that window. The format bits can change only while the window is open and UART mode is already selected. The two enables can change only while UART mode is selected. A three-bit status register records three events: transmit done, receive ready and parity error. Writing 1 to a status bit clears it. A programmable divider produces the oversampling tick, so one bit lasts 16 × (divider + 1) clocks.

Top module: `uart_frame_xcvr`

## Requirements
- R1: After reset the control readback `ctrl_q`, the status `stat_q` and the divider are all zero except that the divider holds its default of 1, and `txd` is high.
- R2: Control bit 1 (UART mode) takes the written value only when control bit 0 (setup window) was 1 before the write; bit 0 itself is always writable.
- R3: Control bits 2 (data size, 0 = 7 data bits, 1 = 8 data bits), 3 (parity enable) and 4 (parity sense, 0 = even, 1 = odd) change only when bits 0 and 1 were both 1 before the write.
- R4: Control bits 5 (transmit enable) and 6 (receive enable) change only when bit 1 was 1 before the write.
- R5: A transmitted frame is one low start bit, the data LSB first, then the parity bit when present, then one high stop bit; each bit lasts 16 × (divider + 1) clocks, where the divider is written at address 3; the line idles high.
- R6: With data size 0 a frame always carries 7 data bits plus a parity bit. With data size 1 it carries 8 data bits, and a ninth parity bit only when parity is enabled.
- R7: The parity bit makes the total number of ones among the data and parity bits even when the sense bit is 0, and odd when it is 1.
- R8: A data write (address 1) while transmit enable is 0 or UART mode is 0 is dropped: no frame is sent then or later, and status bit 0 stays 0.
- R9: A data write during a frame is held and sent after that frame's stop bit. Status bit 0 (transmit done) sets at the end of every stop bit.
- R10: After a received frame's stop-bit sample, `rx_data` holds the character (bit 7 is 0 in 7-bit mode) and status bit 1 (receive ready) sets.
- R11: When parity is enabled and the received parity bit disagrees with the configured sense, status bit 2 sets together with bit 1. With parity disabled, bit 2 never sets.
- R12: Writing the status register (address 2) clears each bit written as 1 and leaves each bit written as 0; a new event in the same cycle wins over the clear.
- R13: While receive enable is 0 a frame on `rxd` is not received: status bit 1 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 transmit data, 2 status clear, 3 divider |
| wr_data | input | REG_W | Write data |
| ctrl_q | output | 7 | Control register readback |
| stat_q | output | 3 | Status: bit 0 transmit done, bit 1 receive ready, bit 2 parity error |
| rx_data | output | 8 | Last received character |
| rxd | input | 1 | Serial input, asynchronous |
| txd | output | 1 | Serial output |

## Verification
Frames are sent in all three size and parity combinations, with both parity senses and with data whose parity is odd and even. A decoder checks every bit of the line, so a wrong bit count, bit order or parity sense shows up as a specific bit mismatch. The transmit line is looped back to the receiver, which shows that the receiver agrees with the transmitter. Frames driven directly with a wrong parity bit separate a correct parity checker from one that ignores parity or checks it when disabled. Back-to-back writes, writes with the transmitter disabled, a second divider value and control writes in each lock state separate holding from dropping, bit timing errors, and a register that ignores its lock.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int unsigned FRAME_MAX = 11;
  localparam int unsigned FCNT_W    = 4;

  typedef struct packed {
    logic par_odd;
    logic par_en;
    logic wide;
  } fmt_t;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_DATA = 2'd1,
    A_STAT = 2'd2,
    A_BAUD = 2'd3
  } addr_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rx_state_e;

  function automatic logic par_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction
endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q >= div);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] data,
  input  fmt_t       fmt,
  output logic       txd,
  output logic       busy,
  output logic       done
);
  localparam int unsigned SUB_W = $clog2(OVS);

  logic                 busy_q, busy_d, txd_q, txd_d;
  logic [FRAME_MAX-1:0] sh_q, sh_d, frame;
  logic [FCNT_W-1:0]    left_q, left_d, nbits;
  logic [SUB_W-1:0]     sub_q, sub_d;

  always_comb begin
    frame = '1;
    frame[0] = 1'b0;
    if (!fmt.wide) begin
      frame[7:1] = data[6:0];
      frame[8]   = par_of({1'b0, data[6:0]}, fmt.par_odd);
      nbits      = FCNT_W'(10);
    end else if (!fmt.par_en) begin
      frame[8:1] = data;
      nbits      = FCNT_W'(10);
    end else begin
      frame[8:1] = data;
      frame[9]   = par_of(data, fmt.par_odd);
      nbits      = FCNT_W'(11);
    end
  end

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    left_d = left_q;
    sub_d  = sub_q;
    txd_d  = txd_q;
    done   = 1'b0;
    if (!busy_q) begin
      txd_d = 1'b1;
      if (load) begin
        busy_d = 1'b1;
        txd_d  = frame[0];
        sh_d   = {1'b1, frame[FRAME_MAX-1:1]};
        left_d = nbits - 1'b1;
        sub_d  = '0;
      end
    end else if (tick) begin
      if (sub_q == SUB_W'(OVS-1)) begin
        sub_d = '0;
        if (left_q == '0) begin
          busy_d = 1'b0;
          txd_d  = 1'b1;
          done   = 1'b1;
        end else begin
          txd_d  = sh_q[0];
          sh_d   = {1'b1, sh_q[FRAME_MAX-1:1]};
          left_d = left_q - 1'b1;
        end
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      sub_q  <= '0;
      txd_q  <= 1'b1;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      sub_q  <= sub_d;
      txd_q  <= txd_d;
    end
  end

  assign txd  = txd_q;
  assign busy = busy_q;

  assert_stop_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && left_q == '0) |-> txd_q);
  assert_load_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);
  assert_done_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (txd_q && !busy_q));
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       rxd,
  input  fmt_t       fmt,
  output logic [7:0] data,
  output logic       valid,
  output logic       perr
);
  localparam int unsigned SUB_W = $clog2(OVS);
  localparam int unsigned MID   = OVS/2 - 1;

  logic [2:0]        sync_q;
  rx_state_e         st_q, st_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [FCNT_W-1:0] idx_q, idx_d, nb;
  logic [8:0]        sh_q, sh_d;
  fmt_t              fl_q, fl_d;
  logic [7:0]        data_q, data_d, ch;
  logic              valid_q, valid_d, perr_q, perr_d, pbit, fin, s_cur, s_prev;

  assign s_cur  = sync_q[1];
  assign s_prev = sync_q[2];

  always_comb begin
    nb = fl_q.wide ? (fl_q.par_en ? FCNT_W'(9) : FCNT_W'(8)) : FCNT_W'(8);
    ch   = fl_q.wide ? sh_q[7:0] : {1'b0, sh_q[6:0]};
    pbit = fl_q.wide ? sh_q[8] : sh_q[7];
  end

  always_comb begin
    st_d  = st_q;
    sub_d = sub_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    fl_d  = fl_q;
    fin   = 1'b0;
    case (st_q)
      RX_IDLE: if (en && s_prev && !s_cur) begin
        st_d  = RX_START;
        sub_d = '0;
        fl_d  = fmt;
      end
      RX_START: if (tick) begin
        if (sub_q == SUB_W'(MID)) begin
          sub_d = '0;
          idx_d = '0;
          st_d  = s_cur ? RX_IDLE : RX_BITS;
        end else begin
          sub_d = sub_q + 1'b1;
        end
      end
      RX_BITS: if (tick) begin
        if (sub_q == SUB_W'(OVS-1)) begin
          sub_d = '0;
          if (idx_q == nb) begin
            st_d = RX_IDLE;
            fin  = 1'b1;
          end else begin
            sh_d[idx_q] = s_cur;
            idx_d       = idx_q + 1'b1;
          end
        end else begin
          sub_d = sub_q + 1'b1;
        end
      end
      default: st_d = RX_IDLE;
    endcase
    data_d  = fin ? ch : data_q;
    valid_d = fin;
    perr_d  = fin && fl_q.par_en && (pbit != par_of(ch, fl_q.par_odd));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      st_q    <= RX_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      fl_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[1:0], rxd};
      st_q    <= st_d;
      sub_q   <= sub_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      fl_q    <= fl_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      perr_q  <= perr_d;
    end
  end

  assign data  = data_q;
  assign valid = valid_q;
  assign perr  = perr_q;

  assert_perr_with_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    perr_q |-> valid_q);
  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  assert_narrow_top_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !fl_q.wide) |-> !data_q[7]);
endmodule

// File: rtl/uart_frame_xcvr.sv
module uart_frame_xcvr
  import uart_pkg::*;
#(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned OVS     = 16,
  parameter int unsigned DEF_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic [6:0]       ctrl_q,
  output logic [2:0]       stat_q,
  output logic [7:0]       rx_data,
  input  logic             rxd,
  output logic             txd
);
  logic [1:0]       rst_ff;
  logic             rst_i;
  logic             init_q, init_d, mode_q, mode_d;
  fmt_t             fmt_q, fmt_d;
  logic [1:0]       en_q, en_d;
  logic [REG_W-1:0] div_q, div_d;
  logic [2:0]       st_q, st_d, set_v;
  logic             pend_q, pend_d, load, tick, tx_busy, tx_done, rx_valid, rx_perr;
  logic [7:0]       pdat_q, pdat_d;
  logic             w_ctrl, w_data, w_stat, w_baud;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_i = rst_ff[1];

  always_comb begin
    w_ctrl = wr_en && (addr_e'(wr_addr) == A_CTRL);
    w_data = wr_en && (addr_e'(wr_addr) == A_DATA);
    w_stat = wr_en && (addr_e'(wr_addr) == A_STAT);
    w_baud = wr_en && (addr_e'(wr_addr) == A_BAUD);
    init_d = init_q;
    mode_d = mode_q;
    fmt_d  = fmt_q;
    en_d   = en_q;
    if (w_ctrl) begin
      init_d = wr_data[0];
      if (init_q)           mode_d = wr_data[1];
      if (init_q && mode_q) fmt_d  = fmt_t'(wr_data[4:2]);
      if (mode_q)           en_d   = wr_data[6:5];
    end
    div_d  = w_baud ? wr_data : div_q;
    load   = pend_q && !tx_busy;
    pend_d = pend_q;
    pdat_d = pdat_q;
    if (load) pend_d = 1'b0;
    if (w_data && en_q[0] && mode_q) begin
      pend_d = 1'b1;
      pdat_d = wr_data[7:0];
    end
    set_v = {rx_perr, rx_valid, tx_done};
    st_d  = (st_q & ~(w_stat ? wr_data[2:0] : 3'b000)) | set_v;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      init_q <= 1'b0;
      mode_q <= 1'b0;
      fmt_q  <= '0;
      en_q   <= '0;
      div_q  <= REG_W'(DEF_DIV);
      st_q   <= '0;
      pend_q <= 1'b0;
      pdat_q <= '0;
    end else begin
      init_q <= init_d;
      mode_q <= mode_d;
      fmt_q  <= fmt_d;
      en_q   <= en_d;
      div_q  <= div_d;
      st_q   <= st_d;
      pend_q <= pend_d;
      pdat_q <= pdat_d;
    end
  end

  uart_baud #(.DIV_W(REG_W)) u_baud (
    .clk(clk), .rst_n(rst_i), .div(div_q), .tick(tick)
  );

  uart_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_i), .tick(tick), .load(load), .data(pdat_q),
    .fmt(fmt_q), .txd(txd), .busy(tx_busy), .done(tx_done)
  );

  uart_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_i), .tick(tick), .en(en_q[1] && mode_q), .rxd(rxd),
    .fmt(fmt_q), .data(rx_data), .valid(rx_valid), .perr(rx_perr)
  );

  assign ctrl_q = {en_q, fmt_q, mode_q, init_q};
  assign stat_q = st_q;

  assert_mode_lock_R2: assert property (@(posedge clk) disable iff (!rst_i)
    !init_q |=> $stable(mode_q));
  assert_fmt_lock_R3: assert property (@(posedge clk) disable iff (!rst_i)
    !(init_q && mode_q) |=> $stable(fmt_q));
  assert_en_lock_R4: assert property (@(posedge clk) disable iff (!rst_i)
    !mode_q |=> $stable(en_q));
  assert_w1c_R12: assert property (@(posedge clk) disable iff (!rst_i)
    (w_stat && set_v == 3'b000) |=> ((stat_q & $past(wr_data[2:0])) == 3'b000));
  assert_drop_disabled_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (!pend_q && !(en_q[0] && mode_q)) |=> !pend_q);
endmodule

// File: tb/tb_uart_frame_xcvr.sv
module tb_uart_frame_xcvr;
  logic        clk, rst_n, wr_en, rxd, txd, loop, line;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [6:0]  ctrl_q, m_ctrl;
  logic [2:0]  stat_q;
  logic [7:0]  rx_data;
  int checks, errors, bitclk;
  logic done_run;

  uart_frame_xcvr dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .rx_data(rx_data), .rxd(rxd), .txd(txd)
  );

  assign rxd = loop ? txd : line;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Reference model of the control register lock rules (R2, R3, R4)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_ctrl <= '0;
    else if (wr_en && wr_addr == 2'd0) begin
      m_ctrl[0] <= wr_data[0];
      if (m_ctrl[0]) m_ctrl[1] <= wr_data[1];
      if (m_ctrl[0] && m_ctrl[1]) m_ctrl[4:2] <= wr_data[4:2];
      if (m_ctrl[1]) m_ctrl[6:5] <= wr_data[6:5];
    end
  end

  always @(negedge clk) if (rst_n && !done_run) chk("R2_R3_R4 ctrl model", int'(ctrl_q), int'(m_ctrl));

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_fmt(input logic w, input logic p, input logic o, input logic te, input logic re);
    wr(2'd0, 16'h0001);
    wr(2'd0, 16'h0003);
    wr(2'd0, {9'd0, 1'b0, 1'b0, o, p, w, 2'b11});
    wr(2'd0, {9'd0, re, te, o, p, w, 2'b10});
  endtask

  task automatic exp_frame(input logic [7:0] d, input logic w, input logic p, input logic o,
                           output logic [10:0] f, output int n);
    int ones;
    f = '1; f[0] = 1'b0; ones = 0;
    if (!w) begin
      for (int i = 0; i < 7; i++) begin f[1+i] = d[i]; ones += int'(d[i]); end
      f[8] = o ? ((ones % 2) == 0) : ((ones % 2) == 1);
      n = 10;
    end else begin
      for (int i = 0; i < 8; i++) begin f[1+i] = d[i]; ones += int'(d[i]); end
      if (p) begin f[9] = o ? ((ones % 2) == 0) : ((ones % 2) == 1); n = 11; end
      else n = 10;
    end
  endtask

  task automatic capture(input int n, output logic [10:0] got);
    int t;
    got = '1; t = 0;
    while (txd && t < 6000) begin @(negedge clk); t++; end
    repeat (bitclk/2) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (bitclk) @(negedge clk);
      got[i] = txd;
    end
  endtask

  task automatic tx_case(input string tag, input logic [7:0] d, input logic w, input logic p, input logic o);
    logic [10:0] f, got;
    int n;
    exp_frame(d, w, p, o, f, n);
    wr(2'd1, {8'd0, d});
    capture(n, got);
    chk(tag, int'(got), int'(f));
    repeat (bitclk + 8) @(negedge clk);
    chk({tag, " R9 done + R10 ready"}, int'(stat_q), 3'b011);
    chk({tag, " R10 loopback data"}, int'(rx_data), int'(w ? d : {1'b0, d[6:0]}));
    wr(2'd2, 16'h0007);
  endtask

  task automatic drive(input logic [10:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      line = f[i];
      repeat (bitclk) @(negedge clk);
    end
    line = 1'b1;
    repeat (bitclk) @(negedge clk);
  endtask

  task automatic finish_run;
    done_run = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [10:0] f, got;
    int n, lows;
    checks = 0; errors = 0; done_run = 1'b0; bitclk = 32;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; loop = 1'b1; line = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ctrl reset", int'(ctrl_q), 0);
    chk("R1 stat reset", int'(stat_q), 0);
    chk("R1 txd idle", int'(txd), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 / R4: mode and enables locked with setup window closed, mode 0
    wr(2'd0, 16'h0062);
    chk("R2 R4 locked write", int'(ctrl_q), 0);
    // R3: format locked while mode still 0 in setup window
    wr(2'd0, 16'h0001);
    wr(2'd0, 16'h001F);
    chk("R3 fmt locked, mode opens", int'(ctrl_q), 7'h03);
    wr(2'd0, 16'h001F);
    chk("R3 fmt written", int'(ctrl_q), 7'h1F);
    // close window with enables on, then try format change
    wr(2'd0, 16'h007E);
    chk("R4 enables written", int'(ctrl_q), 7'h7E);
    wr(2'd0, 16'h0062);
    chk("R3 fmt locked after setup", int'(ctrl_q), 7'h7E);

    // R5 R6 R7 transmit formats with loopback
    set_fmt(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    tx_case("R6 R7 7bit even 0x53", 8'hD3, 1'b0, 1'b0, 1'b0);
    set_fmt(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    tx_case("R6 R7 7bit odd 0x21", 8'h21, 1'b0, 1'b1, 1'b1);
    set_fmt(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    tx_case("R5 R6 8bit no parity 0xA5", 8'hA5, 1'b1, 1'b0, 1'b0);
    set_fmt(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    tx_case("R7 9bit even 0x81", 8'h81, 1'b1, 1'b1, 1'b0);
    set_fmt(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    tx_case("R7 9bit odd 0xF7", 8'hF7, 1'b1, 1'b1, 1'b1);

    // R5 second divider value: bit = 48 clocks
    wr(2'd3, 16'h0002);
    bitclk = 48;
    tx_case("R5 divider 2 frame 0x3C", 8'h3C, 1'b1, 1'b1, 1'b1);
    wr(2'd3, 16'h0001);
    bitclk = 32;

    // R9 back-to-back writes
    set_fmt(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    wr(2'd1, 16'h0011);
    wr(2'd1, 16'h00E2);
    exp_frame(8'h11, 1'b1, 1'b0, 1'b0, f, n);
    capture(n, got);
    chk("R9 first frame", int'(got), int'(f));
    exp_frame(8'hE2, 1'b1, 1'b0, 1'b0, f, n);
    capture(n, got);
    chk("R9 held frame", int'(got), int'(f));
    repeat (bitclk + 8) @(negedge clk);
    chk("R9 rx got second", int'(rx_data), 8'hE2);
    chk("R9 done set", int'(stat_q[0]), 1);

    // R12 write-1-to-clear
    wr(2'd2, 16'h0000);
    chk("R12 zero write keeps", int'(stat_q), 3'b011);
    wr(2'd2, 16'h0002);
    chk("R12 clear bit1 only", int'(stat_q), 3'b001);
    wr(2'd2, 16'h0001);
    chk("R12 clear bit0", int'(stat_q), 3'b000);

    // R8 transmit disabled: write dropped, not sent later
    set_fmt(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    wr(2'd1, 16'h0055);
    lows = 0;
    repeat (400) begin @(negedge clk); if (!txd) lows++; end
    chk("R8 no frame while disabled", lows, 0);
    chk("R8 no done", int'(stat_q[0]), 0);
    wr(2'd0, 16'h0022);
    repeat (400) begin @(negedge clk); if (!txd) lows++; end
    chk("R8 dropped write not sent later", lows, 0);

    // R11 parity error with direct drive
    loop = 1'b0;
    set_fmt(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    exp_frame(8'h35, 1'b1, 1'b1, 1'b0, f, n);
    f[9] = ~f[9];
    drive(f, n);
    chk("R11 bad parity flags", int'(stat_q), 3'b110);
    chk("R10 R11 data kept", int'(rx_data), 8'h35);
    wr(2'd2, 16'h0007);
    exp_frame(8'h35, 1'b1, 1'b1, 1'b0, f, n);
    drive(f, n);
    chk("R11 good parity", int'(stat_q), 3'b010);
    wr(2'd2, 16'h0007);
    set_fmt(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    exp_frame(8'h2A, 1'b0, 1'b0, 1'b0, f, n);
    f[8] = ~f[8];
    drive(f, n);
    chk("R11 parity off no error", int'(stat_q), 3'b010);
    chk("R10 7bit data", int'(rx_data), 8'h2A);
    wr(2'd2, 16'h0007);

    // R13 receiver disabled
    set_fmt(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    exp_frame(8'h66, 1'b1, 1'b0, 1'b0, f, n);
    drive(f, n);
    chk("R13 no receive", int'(stat_q), 3'b000);
    chk("R13 data unchanged", int'(rx_data), 8'h2A);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule